// File: doc/BRIEF.md
# Non-Volatile Wiper Store Sequencer

This block receives wiper settings over a chip-select framed serial line and decides when a received setting is also saved into non-volatile storage. Each frame carries an address that selects one of several wiper registers and a data byte that becomes that register's new value. If the program request input is high at the clock edge right after the last data bit, the block starts an erase/write cycle of a fixed number of clocks. At the end of that cycle the byte is written into the matching non-volatile entry.

While a store runs, an active-low ready/busy output is held low, the serial receiver ignores its data input and the serial output enable stays off. The store is gated by a supply-good input from a low-voltage detector. If the supply is too low when the request arrives, no cycle starts and ready/busy stays high, which tells the host that the data was not saved. The non-volatile array is a plain register array. A power-on reset fills it with a fixed factory value. A synchronous warm reset copies the stored contents back into the wiper registers, which stands in for the recall a real part performs at power-up.

During the data phase of every frame, the serial output shifts out the current value of the addressed wiper, least significant bit first. A host can therefore read a register while it writes it.

Top module: `nvs_top`

## Requirements
- R1: An active power-on reset (por_ni low) sets every non-volatile entry and every wiper to NV_INIT (default 0x80). While rst_ni is low at a rising edge, each wiper is loaded from its non-volatile entry and the control state goes idle. After either reset, rdy_o is 1 and do_oe_o is 0 while cs_i is low.
- R2: With cs_i high, di_i is sampled on rising edges. Zeros seen before the start bit are skipped. A frame is a start bit of value 1, then two address bits with bit 0 first, then eight data bits with bit 0 first. The addressed wiper takes the data byte at the rising edge that follows the edge which sampled the last data bit.
- R3: do_oe_o equals cs_i AND rdy_o. During the eight cycles in which data bits are being received, do_o carries the addressed wiper's value as it was before the frame, bit 0 first, one bit per cycle. At other times do_o is 0.
- R4: If prog_i and supply_ok_i are both high at the edge after the last data bit, rdy_o goes low from that edge and stays low for exactly PROG_CYCLES clock cycles (default 64).
- R5: When a store completes, the addressed non-volatile entry holds the frame's data byte. A later warm reset brings that value back into the wiper.
- R6: While rdy_o is low, do_oe_o is 0, di_i is ignored and the wiper values do not change.
- R7: If prog_i is high and supply_ok_i is low at the edge after the last data bit, rdy_o stays high and the non-volatile contents are unchanged. The wiper still takes the new byte.
- R8: If chip select drops before a frame is complete, prog_i has no effect and no wiper changes.
- R9: A complete frame with prog_i low updates the wiper only. The non-volatile entry keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial and sequencer clock; must keep running during a store |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_ni | input | 1 | Synchronous warm reset with recall from storage, active low |
| cs_i | input | 1 | Chip select, high frames a transfer |
| di_i | input | 1 | Serial data in |
| prog_i | input | 1 | Store request, sampled at the edge after the last data bit |
| supply_ok_i | input | 1 | Supply high enough for programming |
| do_o | output | 1 | Serial data out, current wiper value, bit 0 first |
| do_oe_o | output | 1 | Output enable for do_o |
| rdy_o | output | 1 | Ready (1) or busy storing (0) |
| wiper_o | output | 4*DATA_W | Wiper registers, entry k at bits [k*DATA_W +: DATA_W] |

## Verification
The hard cases are the non-volatile contents, which never appear at the ports, and the claim that a store attempted at low supply changed nothing. The bench reaches both with the warm reset. It performs a store, a plain write and a low-supply store, then pulses rst_ni and reads back through wiper_o which values were recalled from storage. Traffic that should be ignored is driven during the busy window. This includes a frame that begins with a valid start bit, and the bench confirms that no wiper moves and that the output enable stays off.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_FULL = 2'd3
    } rx_phase_e;

endpackage

// File: rtl/nvs_frame_rx.sv
module nvs_frame_rx #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                      clk_i,
    input  logic                      por_ni,
    input  logic                      clr_i,
    input  logic                      cs_i,
    input  logic                      di_i,
    input  logic                      hold_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic [DATA_W-1:0]         data_o,
    output logic                      full_o,
    output logic                      dout_valid_o,
    output logic [$clog2(DATA_W)-1:0] dout_idx_o
);
    import nvs_pkg::*;

    localparam int IW  = $clog2(DATA_W);
    localparam int AIW = $clog2(ADDR_W);

    typedef struct packed {
        rx_phase_e         phase;
        logic [IW-1:0]     idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (di_i) begin
                    d.phase = PH_ADDR;
                    d.idx   = '0;
                end
            end
            PH_ADDR: begin
                d.addr[q.idx[AIW-1:0]] = di_i;
                if (q.idx == IW'(ADDR_W - 1)) begin
                    d.phase = PH_DATA;
                    d.idx   = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            PH_DATA: begin
                d.data[q.idx] = di_i;
                if (q.idx == IW'(DATA_W - 1)) begin
                    d.phase = PH_FULL;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            PH_FULL: begin
                d.phase = PH_IDLE;
                d.idx   = '0;
            end
            default: d.phase = PH_IDLE;
        endcase
        if (!cs_i || hold_i || clr_i) begin
            d.phase = PH_IDLE;
            d.idx   = '0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            q <= '{phase: PH_IDLE, idx: '0, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign addr_o       = q.addr;
    assign data_o       = q.data;
    assign full_o       = (q.phase == PH_FULL);
    assign dout_valid_o = (q.phase == PH_DATA);
    assign dout_idx_o   = q.idx;

endmodule

// File: rtl/nvs_store_ctl.sv
module nvs_store_ctl #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic clr_i,
    input  logic start_i,
    input  logic supply_ok_i,
    output logic busy_o,
    output logic commit_o
);
    localparam int CW = $clog2(PROG_CYCLES);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } ctl_state_t;

    ctl_state_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (start_i && supply_ok_i) begin
            d.busy = 1'b1;
            d.cnt  = CW'(PROG_CYCLES - 1);
        end
        if (clr_i) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            q <= '{busy: 1'b0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign commit_o = q.busy && (q.cnt == '0) && !clr_i;

endmodule

// File: rtl/nvs_top.sv
module nvs_top #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 2,
    parameter int                PROG_CYCLES = 64,
    parameter logic [DATA_W-1:0] NV_INIT     = 8'h80
) (
    input  logic                            clk_i,
    input  logic                            por_ni,
    input  logic                            rst_ni,
    input  logic                            cs_i,
    input  logic                            di_i,
    input  logic                            prog_i,
    input  logic                            supply_ok_i,
    output logic                            do_o,
    output logic                            do_oe_o,
    output logic                            rdy_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0]   wiper_o
);
    localparam int NUM = 1 << ADDR_W;
    localparam int IW  = $clog2(DATA_W);

    typedef struct packed {
        logic [NUM-1:0][DATA_W-1:0] wiper;
        logic [NUM-1:0][DATA_W-1:0] nv;
        logic [ADDR_W-1:0]          pend_addr;
        logic [DATA_W-1:0]          pend_data;
    } top_state_t;

    top_state_t q, d;

    logic              busy;
    logic              commit;
    logic              frame_full;
    logic [ADDR_W-1:0] rx_addr;
    logic [DATA_W-1:0] rx_data;
    logic              dout_valid;
    logic [IW-1:0]     dout_idx;

    nvs_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_rx (
        .clk_i        (clk_i),
        .por_ni       (por_ni),
        .clr_i        (!rst_ni),
        .cs_i         (cs_i),
        .di_i         (di_i),
        .hold_i       (busy),
        .addr_o       (rx_addr),
        .data_o       (rx_data),
        .full_o       (frame_full),
        .dout_valid_o (dout_valid),
        .dout_idx_o   (dout_idx)
    );

    nvs_store_ctl #(
        .PROG_CYCLES (PROG_CYCLES)
    ) i_ctl (
        .clk_i       (clk_i),
        .por_ni      (por_ni),
        .clr_i       (!rst_ni),
        .start_i     (frame_full && prog_i),
        .supply_ok_i (supply_ok_i),
        .busy_o      (busy),
        .commit_o    (commit)
    );

    always_comb begin
        d = q;
        if (!rst_ni) begin
            d.wiper = q.nv;
        end else if (frame_full) begin
            d.wiper[rx_addr] = rx_data;
            d.pend_addr      = rx_addr;
            d.pend_data      = rx_data;
        end
        if (commit) begin
            d.nv[q.pend_addr] = q.pend_data;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            q.wiper     <= {NUM{NV_INIT}};
            q.nv        <= {NUM{NV_INIT}};
            q.pend_addr <= '0;
            q.pend_data <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdy_o   = !busy;
    assign do_oe_o = cs_i && !busy;
    assign do_o    = (do_oe_o && dout_valid) ? q.wiper[rx_addr][dout_idx] : 1'b0;
    assign wiper_o = q.wiper;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int PROG_CYCLES = 64
) (
    input logic                          clk_i,
    input logic                          por_ni,
    input logic                          rst_ni,
    input logic                          prog_i,
    input logic                          supply_ok_i,
    input logic                          rdy_o,
    input logic                          do_oe_o,
    input logic [(1<<ADDR_W)*DATA_W-1:0] wiper_o,
    input logic                          frame_full_i,
    input logic                          commit_i,
    input logic [(1<<ADDR_W)*DATA_W-1:0] nv_i
);
    localparam int CW = $clog2(PROG_CYCLES + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            busy_cnt <= '0;
        end else if (!rst_ni || rdy_o) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R4: busy window has the programmed length
    a_r4_busy_len: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        $rose(rdy_o) && $past(rst_ni) |-> busy_cnt == CW'(PROG_CYCLES));

    a_r4_store_start: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        frame_full_i && prog_i && supply_ok_i && rdy_o |=> !rdy_o);

    a_r7_low_supply: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        frame_full_i && prog_i && !supply_ok_i && rdy_o |=> rdy_o);

    a_r6_no_drive: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        !rdy_o |-> !do_oe_o);

    a_r6_wiper_hold: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        !rdy_o |=> $stable(wiper_o));

    a_r5_nv_on_commit: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        !commit_i |=> $stable(nv_i));

    a_r8_no_spurious_busy: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        rdy_o && !frame_full_i |=> rdy_o);

endmodule

bind nvs_top nvs_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
) i_nvs_checker (
    .clk_i        (clk_i),
    .por_ni       (por_ni),
    .rst_ni       (rst_ni),
    .prog_i       (prog_i),
    .supply_ok_i  (supply_ok_i),
    .rdy_o        (rdy_o),
    .do_oe_o      (do_oe_o),
    .wiper_o      (wiper_o),
    .frame_full_i (frame_full),
    .commit_i     (commit),
    .nv_i         (q.nv)
);

// File: tb/test_nvs_top.sv
`timescale 1ns/1ps
module test_nvs_top;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int PROG_CYCLES = 64;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic di = 1'b0;
    logic prog = 1'b0;
    logic sup_ok = 1'b1;
    logic do_s, do_oe, rdy;
    logic [4*DATA_W-1:0] wiper;

    int checks = 0;
    int errors = 0;
    logic do_chk = 1'b0;
    logic exp_q[$];

    always #10 clk = ~clk;

    nvs_top i_nvs_top (
        .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .cs_i(cs), .di_i(di),
        .prog_i(prog), .supply_ok_i(sup_ok), .do_o(do_s), .do_oe_o(do_oe),
        .rdy_o(rdy), .wiper_o(wiper)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wp(input int a);
        return wiper[a*DATA_W +: DATA_W];
    endfunction

    // scoreboard monitor: compares serial output against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (do_chk && exp_q.size() > 0) begin
                logic e;
                e = exp_q.pop_front();
                check("R3 do_o bit", 32'(do_s), 32'(e));
                check("R3 do_oe_o", 32'(do_oe), 32'd1);
            end
        end
    end

    task automatic send_frame(input logic [1:0] a, input logic [7:0] dat,
                              input logic pr, input int lead, input logic [7:0] old);
        @(negedge clk); cs = 1'b1; di = 1'b0;
        for (int i = 0; i < lead; i++) @(negedge clk);
        di = 1'b1;
        @(negedge clk); di = a[0]; prog = pr;
        @(negedge clk); di = a[1];
        for (int j = 0; j < 8; j++) begin
            @(negedge clk); di = dat[j]; exp_q.push_back(old[j]); do_chk = 1'b1;
        end
        @(negedge clk); do_chk = 1'b0; di = 1'b0;
        @(negedge clk); cs = 1'b0; prog = 1'b0;
    endtask

    task automatic warm_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy_o", 32'(rdy), 32'd1);
        check("R1 do_oe_o", 32'(do_oe), 32'd0);
        for (int k = 0; k < 4; k++) check("R1 wiper init", 32'(wp(k)), 32'h80);

        // R2/R9 plain write, no store
        send_frame(2'd1, 8'h5A, 1'b0, 0, 8'h80);
        check("R2 wiper1 updated", 32'(wp(1)), 32'h5A);
        check("R9 rdy_o stays high", 32'(rdy), 32'd1);

        // R2 idle zeros before start bit skipped
        send_frame(2'd0, 8'h3C, 1'b0, 3, 8'h80);
        check("R2 wiper0 after lead zeros", 32'(wp(0)), 32'h3C);

        // R3 readback of a written value
        send_frame(2'd1, 8'hA7, 1'b0, 0, 8'h5A);
        check("R2 wiper1 rewritten", 32'(wp(1)), 32'hA7);

        // R4 store with good supply
        send_frame(2'd2, 8'hC3, 1'b1, 0, 8'h80);
        check("R4 rdy_o low after store edge", 32'(rdy), 32'd0);
        check("R2 wiper2 updated", 32'(wp(2)), 32'hC3);
        begin
            int n;
            n = 0;
            cs = 1'b1;
            while (rdy == 1'b0 && n < 1000) begin
                n++;
                // R6: traffic with a start bit during busy
                di = (n % 3 != 0);
                if (n == 5) check("R6 do_oe_o low while busy", 32'(do_oe), 32'd0);
                if (n == 20) check("R6 wiper0 held while busy", 32'(wp(0)), 32'h3C);
                @(negedge clk);
            end
            cs = 1'b0; di = 1'b0;
            check("R4 busy length", 32'(n), 32'(PROG_CYCLES));
        end
        @(negedge clk);
        check("R6 wiper0 after busy traffic", 32'(wp(0)), 32'h3C);
        check("R6 wiper3 after busy traffic", 32'(wp(3)), 32'h80);

        // R5/R9 recall via warm reset
        warm_reset();
        @(negedge clk);
        check("R5 wiper2 recalled", 32'(wp(2)), 32'hC3);
        check("R9 wiper1 recalled old", 32'(wp(1)), 32'h80);
        check("R1 wiper0 recalled", 32'(wp(0)), 32'h80);
        check("R1 rdy_o after warm reset", 32'(rdy), 32'd1);

        // R7 store attempt at low supply
        sup_ok = 1'b0;
        send_frame(2'd3, 8'h11, 1'b1, 0, 8'h80);
        check("R7 rdy_o stays high", 32'(rdy), 32'd1);
        repeat (3) @(negedge clk);
        check("R7 rdy_o still high", 32'(rdy), 32'd1);
        check("R7 wiper3 updated", 32'(wp(3)), 32'h11);
        sup_ok = 1'b1;
        warm_reset();
        @(negedge clk);
        check("R7 nv3 unchanged", 32'(wp(3)), 32'h80);

        // R8 incomplete frame with prog high
        @(negedge clk); cs = 1'b1; di = 1'b1;
        @(negedge clk); di = 1'b0; prog = 1'b1;
        @(negedge clk); di = 1'b1;
        for (int j = 0; j < 3; j++) begin @(negedge clk); di = 1'b0; end
        @(negedge clk); cs = 1'b0;
        repeat (4) @(negedge clk);
        prog = 1'b0;
        check("R8 rdy_o stays high", 32'(rdy), 32'd1);
        check("R8 wiper2 unchanged", 32'(wp(2)), 32'hC3);
        check("R8 do_oe_o off", 32'(do_oe), 32'd0);

        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule